// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block is the hazard control unit for an in-order, single-issue processor pipeline of eight stages (IF, IS, RF, EX, DF, DS, TC, WB). It receives the decoded fields of the instruction now in RF. When that instruction advances, the block keeps a shadow copy of it and of the four instructions ahead of it, so it knows every in-flight destination register. Each cycle it drives three kinds of control. The first is operand-forwarding selects for both ALU inputs of the instruction in EX. The second is hold enables for the front-end stages and a bubble-insert flag for DF while a multi-cycle multiply occupies EX. The third is flush bits for the three front-end stages when a branch in EX resolves as taken.

Register results are written back only in the last stage. An ALU result made in EX is therefore still in flight through DF, DS, TC and WB while the next four instructions reach EX. The block picks the youngest matching producer among those four pipeline registers. A branch is predicted not taken and resolves at the end of EX. A taken branch turns the three younger instructions into bubbles, which costs three cycles. A multiply stays in EX for a configurable number of cycles, five by default. During that time the front end holds its contents and bubbles flow into DF.

Top module: `hz_ctrl`

## Requirements
- R1: After reset no tracked instruction is valid: both forwarding selects read 0, and the stall, flush and DF-bubble outputs are 0.
- R2: Forwarding select encoding is 0 = register file, 1 = EX/DF register, 2 = DF/DS, 3 = DS/TC, 4 = TC/WB. A consumer directly behind its producer gets select 1 for the matching operand.
- R3: A producer 2, 3 or 4 instructions ahead of the consumer yields select 2, 3 or 4. A producer 5 or more instructions ahead yields 0.
- R4: When several in-flight producers write the consumer's source register, the youngest one (lowest select value) wins. Operands A and B are resolved independently.
- R5: A source register number of 0 always yields select 0, even if a producer writes register 0.
- R6: A producer whose write-enable is 0, or that entered as a bubble (RF valid 0), never matches.
- R7: When EX holds a valid branch (class 2) and the branch-taken input is 1, the flush output is 3'b111 (bit 0 IF, bit 1 IS, bit 2 RF) in that cycle. The RF instruction is discarded and can never be forwarded from.
- R8: A branch in EX with the branch-taken input 0, or an EX instruction that is not a branch, produces no flush. The instruction behind it forwards normally.
- R9: When a multiply (class 1) enters EX, the stall output is 3'b111 and the DF-bubble output is 1 for the first MUL_CYC-1 cycles. Both are 0 in the MUL_CYC-th cycle. The RF instruction is not taken in during the stall.
- R10: A multiply's result is forwardable only after its last EX cycle. The instruction behind it reaches EX one cycle later and sees select 1.
- R11: Flush takes priority: the stall and flush outputs are never both non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rf_valid_i | input | 1 | RF stage holds a real instruction |
| rf_rs_i | input | 5 | RF instruction source A register |
| rf_rt_i | input | 5 | RF instruction source B register |
| rf_rd_i | input | 5 | RF instruction destination register |
| rf_we_i | input | 1 | RF instruction writes its destination |
| rf_cls_i | input | 2 | Class: 0 ALU, 1 multiply, 2 branch, 3 other |
| ex_br_taken_i | input | 1 | Branch in EX resolved taken |
| fwd_a_sel_o | output | 3 | Operand A forwarding select |
| fwd_b_sel_o | output | 3 | Operand B forwarding select |
| fe_stall_o | output | 3 | Hold enables for IF, IS, RF (bits 0..2) |
| fe_flush_o | output | 3 | Squash bits for IF, IS, RF (bits 0..2) |
| df_bubble_o | output | 1 | Insert a bubble into DF this cycle |

## Verification
The assertions check the following on every cycle. A non-zero select always points at a valid, writing producer whose destination equals the source. Register zero never forwards. The multiply counter stays in range, and the multiply stays in EX while the hold is asserted. A hold leaves a bubble in DF, a taken branch leaves EX empty, and stall and flush are never raised together. Only the bench scenarios can show the stage distances behind each select value and the youngest-first choice among several writers. They also show that the stall lasts exactly MUL_CYC-1 cycles, and that a squashed or bubble instruction never forwards later.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int REG_W = 5;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_MUL   = 2'd1,
        CLS_BRANCH= 2'd2,
        CLS_OTHER = 2'd3
    } cls_e;

    // one tracked in-flight instruction
    typedef struct packed {
        logic             valid;
        logic             we;
        logic [REG_W-1:0] rd;
        cls_e             cls;
    } slot_t;

    // instruction sitting in EX also carries its sources
    typedef struct packed {
        slot_t            slot;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
    } ex_slot_t;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int N_FWD = 4,
    parameter int SEL_W = $clog2(N_FWD + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  use_i,
    input  logic [REG_W-1:0]      src_i,
    input  slot_t [N_FWD-1:0]     prod_i,   // index 0 = youngest (EX/DF)
    output logic [SEL_W-1:0]      sel_o
);

    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        if (use_i && src_i != '0) begin
            for (int k = N_FWD - 1; k >= 0; k--) begin
                if (prod_i[k].valid && prod_i[k].we && prod_i[k].rd == src_i) begin
                    sel_d = SEL_W'(k + 1);
                end
            end
        end
    end

    assign sel_o = sel_d;

    // R5
    zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i == '0) |-> (sel_o == '0));

    // R6
    match_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o != '0) |-> (prod_i[sel_o - SEL_W'(1)].valid && prod_i[sel_o - SEL_W'(1)].we
                           && prod_i[sel_o - SEL_W'(1)].rd == src_i));

    // R2
    sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(sel_o) <= N_FWD);

endmodule

// File: rtl/hz_mul_timer.sv
module hz_mul_timer #(
    parameter int MUL_CYC = 5,
    parameter int CNT_W   = (MUL_CYC > 1) ? $clog2(MUL_CYC) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mul_in_ex_i,
    output logic hold_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MUL_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             hold;

    always_comb begin
        hold  = mul_in_ex_i && (cnt_q != LAST);
        cnt_d = '0;
        if (hold) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hold_o = hold;

    // R9
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) < MUL_CYC);

    // R9
    mul_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_o |=> mul_in_ex_i);

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int MUL_CYC = 5,
    parameter int N_FWD   = 4,
    parameter int N_FE    = 3,
    parameter int SEL_W   = $clog2(N_FWD + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rf_valid_i,
    input  logic [REG_W-1:0]  rf_rs_i,
    input  logic [REG_W-1:0]  rf_rt_i,
    input  logic [REG_W-1:0]  rf_rd_i,
    input  logic              rf_we_i,
    input  logic [1:0]        rf_cls_i,
    input  logic              ex_br_taken_i,
    output logic [SEL_W-1:0]  fwd_a_sel_o,
    output logic [SEL_W-1:0]  fwd_b_sel_o,
    output logic [N_FE-1:0]   fe_stall_o,
    output logic [N_FE-1:0]   fe_flush_o,
    output logic              df_bubble_o
);

    typedef struct packed {
        ex_slot_t             ex;
        slot_t [N_FWD-1:0]    fwd;   // 0: EX/DF ... N_FWD-1: TC/WB
    } state_t;

    state_t state_d, state_q;
    logic   mul_in_ex, hold, taken;

    assign mul_in_ex = state_q.ex.slot.valid && state_q.ex.slot.cls == CLS_MUL;
    assign taken     = state_q.ex.slot.valid && state_q.ex.slot.cls == CLS_BRANCH
                       && ex_br_taken_i;

    hz_mul_timer #(.MUL_CYC(MUL_CYC)) i_mul_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mul_in_ex_i (mul_in_ex),
        .hold_o      (hold)
    );

    always_comb begin
        state_d = state_q;
        // older stages always advance
        for (int k = N_FWD - 1; k > 0; k--) begin
            state_d.fwd[k] = state_q.fwd[k-1];
        end
        if (hold) begin
            state_d.fwd[0]       = '0;
            state_d.fwd[0].cls   = CLS_OTHER;
        end else begin
            state_d.fwd[0]           = state_q.ex.slot;
            state_d.ex.slot.valid    = rf_valid_i && !taken;
            state_d.ex.slot.we       = rf_we_i;
            state_d.ex.slot.rd       = rf_rd_i;
            state_d.ex.slot.cls      = cls_e'(rf_cls_i);
            state_d.ex.rs            = rf_rs_i;
            state_d.ex.rt            = rf_rt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // one picker per ALU operand
    logic [1:0][REG_W-1:0] src;
    logic [1:0][SEL_W-1:0] sel;
    assign src[0] = state_q.ex.rs;
    assign src[1] = state_q.ex.rt;

    for (genvar g = 0; g < 2; g++) begin : g_op
        hz_fwd_pick #(.N_FWD(N_FWD), .SEL_W(SEL_W)) i_pick (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .use_i  (state_q.ex.slot.valid),
            .src_i  (src[g]),
            .prod_i (state_q.fwd),
            .sel_o  (sel[g])
        );
    end

    assign fwd_a_sel_o = sel[0];
    assign fwd_b_sel_o = sel[1];
    assign fe_flush_o  = {N_FE{taken}};
    assign fe_stall_o  = {N_FE{hold && !taken}};
    assign df_bubble_o = hold;

    // R11
    no_stall_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((|fe_stall_o) && (|fe_flush_o)));

    // R9
    df_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        df_bubble_o |=> !state_q.fwd[0].valid);

    // R7
    squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fe_flush_o) |=> !state_q.ex.slot.valid);

    // R9
    stall_hold_ex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|fe_stall_o) |=> $stable(state_q.ex));

endmodule

// File: tb/test_hz_ctrl.sv
module test_hz_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rf_valid;
    logic [4:0] rf_rs, rf_rt, rf_rd;
    logic       rf_we;
    logic [1:0] rf_cls;
    logic       br_taken;
    logic [2:0] sel_a, sel_b, stall, flush;
    logic       df_bub;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hz_ctrl i_hz_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rf_valid_i    (rf_valid),
        .rf_rs_i       (rf_rs),
        .rf_rt_i       (rf_rt),
        .rf_rd_i       (rf_rd),
        .rf_we_i       (rf_we),
        .rf_cls_i      (rf_cls),
        .ex_br_taken_i (br_taken),
        .fwd_a_sel_o   (sel_a),
        .fwd_b_sel_o   (sel_b),
        .fe_stall_o    (stall),
        .fe_flush_o    (flush),
        .df_bubble_o   (df_bub)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // present an instruction in RF, clock it in, settle
    task automatic issue(input logic v, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [4:0] rd, input logic we, input logic [1:0] cls);
        @(negedge clk);
        rf_valid = v; rf_rs = rs; rf_rt = rt; rf_rd = rd; rf_we = we; rf_cls = cls;
        @(posedge clk);
        #1;
    endtask

    task automatic filler(input int n);
        for (int i = 0; i < n; i++) issue(1'b1, 5'd0, 5'd0, 5'd30, 1'b0, 2'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rf_valid = 1'b1; rf_rs = 5'd3; rf_rt = 5'd3; rf_rd = 5'd3; rf_we = 1'b1;
        rf_cls = 2'd0; br_taken = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk("R1 sel_a", sel_a, 0);
        chk("R1 sel_b", sel_b, 0);
        chk("R1 stall", stall, 0);
        chk("R1 flush", flush, 0);
        chk("R1 df_bubble", df_bub, 0);
        filler(5);
    endtask

    task automatic t_distance;
        for (int d = 1; d <= 5; d++) begin
            issue(1'b1, 5'd0, 5'd0, 5'd5, 1'b1, 2'd0);
            filler(d - 1);
            issue(1'b1, 5'd5, 5'd6, 5'd31, 1'b0, 2'd0);
            if (d == 1) chk("R2 dist1 sel_a", sel_a, 1);
            else chk("R3 distance sel_a", sel_a, (d <= 4) ? d : 0);
            chk("R3 other operand", sel_b, 0);
            filler(4);
        end
    endtask

    task automatic t_priority;
        issue(1'b1, 5'd0, 5'd0, 5'd7, 1'b1, 2'd0);
        issue(1'b1, 5'd0, 5'd0, 5'd8, 1'b1, 2'd0);
        issue(1'b1, 5'd0, 5'd0, 5'd7, 1'b1, 2'd0);
        issue(1'b1, 5'd0, 5'd0, 5'd7, 1'b1, 2'd0);
        issue(1'b1, 5'd7, 5'd8, 5'd31, 1'b0, 2'd0);
        chk("R4 youngest wins A", sel_a, 1);
        chk("R4 independent B", sel_b, 3);
        filler(4);
    endtask

    task automatic t_zero_and_nowrite;
        issue(1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 2'd0);
        issue(1'b1, 5'd0, 5'd0, 5'd31, 1'b0, 2'd0);
        chk("R5 reg zero A", sel_a, 0);
        chk("R5 reg zero B", sel_b, 0);
        filler(4);
        issue(1'b1, 5'd0, 5'd0, 5'd11, 1'b0, 2'd0);
        issue(1'b0, 5'd0, 5'd0, 5'd12, 1'b1, 2'd0);
        issue(1'b1, 5'd11, 5'd12, 5'd31, 1'b0, 2'd0);
        chk("R6 no write-enable", sel_a, 0);
        chk("R6 bubble producer", sel_b, 0);
        filler(4);
    endtask

    task automatic t_branch;
        // taken
        issue(1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'd2);
        @(negedge clk);
        br_taken = 1'b1;
        #1;
        chk("R7 flush on taken", flush, 7);
        chk("R11 no stall with flush", stall, 0);
        rf_valid = 1'b1; rf_rs = 5'd0; rf_rt = 5'd0; rf_rd = 5'd13; rf_we = 1'b1; rf_cls = 2'd0;
        @(posedge clk);
        #1;
        br_taken = 1'b0;
        chk("R7 flush one cycle", flush, 0);
        issue(1'b1, 5'd13, 5'd0, 5'd31, 1'b0, 2'd0);
        chk("R7 squashed never forwards", sel_a, 0);
        filler(4);
        // not taken
        issue(1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'd2);
        chk("R8 no flush not taken", flush, 0);
        issue(1'b1, 5'd0, 5'd0, 5'd14, 1'b1, 2'd0);
        issue(1'b1, 5'd14, 5'd0, 5'd31, 1'b0, 2'd0);
        chk("R8 normal forward after branch", sel_a, 1);
        // taken input on a non-branch
        @(negedge clk);
        br_taken = 1'b1;
        #1;
        chk("R8 non-branch ignores taken", flush, 0);
        br_taken = 1'b0;
        filler(4);
    endtask

    task automatic t_multiply;
        issue(1'b1, 5'd0, 5'd0, 5'd15, 1'b1, 2'd1);
        for (int c = 0; c < 4; c++) begin
            chk("R9 stall during multiply", stall, 7);
            chk("R9 df bubble during multiply", df_bub, 1);
            issue(1'b1, 5'd15, 5'd15, 5'd31, 1'b0, 2'd0);
        end
        chk("R9 stall released last cycle", stall, 0);
        chk("R9 no bubble last cycle", df_bub, 0);
        issue(1'b1, 5'd15, 5'd15, 5'd31, 1'b0, 2'd0);
        chk("R10 multiply result from EX/DF", sel_a, 1);
        chk("R10 multiply result operand B", sel_b, 1);
        chk("R9 no stall after multiply", stall, 0);
        filler(5);
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_distance();
        t_priority();
        t_zero_and_nowrite();
        t_branch();
        t_multiply();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule